// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block is the timekeeping core of a real-time clock. It holds eight 8-bit registers, all in BCD, that together give hundredths of a second, seconds, minutes, hours, day of the week, date, month and a two-digit year. A single-cycle enable (`tick_i`) drives the chain. A prescaler turns `TICK_DIV` enable pulses into one hundredth step. Each register passes a carry to the next one when it wraps. The day-of-week and date registers both advance on the carry out of the hours register.

An external serial access engine, which is not part of this block, reads any register through a combinational read port. It writes a whole register with a single-cycle write strobe. The hours register holds its own display-mode bit, so the same register runs either as a 24-hour counter or as a 12-hour counter with a PM flag. The day-of-week register also holds two control bits. One stops the count. The other is a reset-ignore flag, which the block brings out to the access engine.

Top module: `rtc_calendar_core`

## Requirements
- R1: Hundredths count 00 to 99, seconds and minutes 00 to 59, all in BCD. Each field advances by one when the field below it wraps, and it wraps to 00 itself.
- R2: One hundredth step occurs on every `TICK_DIV`-th `tick_i` pulse. A write to register 0 (hundredths) restarts this count, so the next step comes a full `TICK_DIV` pulses later.
- R3: With register 3 bit 7 = 0 (24-hour mode), bits 5:0 hold hours 00 to 23 in BCD, with bit 5 as the tens bit for 20 to 23. Hour 23 wraps to 00 and advances the date.
- R4: With register 3 bit 7 = 1 (12-hour mode), bits 4:0 hold the hour 01 to 12 in BCD and bit 5 is the PM flag (1 = PM). The order is 12, 01, ..., 11. Going from 11 to 12 flips PM. The date advances only when 11 PM becomes 12 AM.
- R5: Register 4 bits 2:0 hold the day of the week, 1 to 7. It advances with the date, and 7 is followed by 1.
- R6: Register 5 (date) runs from 01 to the length of the month. Months 04, 06, 09 and 11 have 30 days, month 02 has 28, and the other months have 31. Month 02 has 29 days when the value of register 7 (year) is divisible by 4. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R7: Register 4 bit 5 = 1 freezes every counter and the prescaler. Register 4 bit 4 is the reset-ignore flag, shown on `rst_ignore_o`. Bit 5 is shown on `osc_off_o`.
- R8: After reset the registers 0 to 7 read 00, 00, 00, 00, 31, 01, 01, 00 (hex). This is midnight in 24-hour mode, day 1, 1 January of year 00, counter stopped, reset-ignore set.
- R9: These bits read 0 whatever was written to them: register 1 bit 7, register 2 bit 7, register 3 bit 6, register 4 bits 7, 6 and 3, register 5 bits 7 and 6, register 6 bits 7 to 5.
- R10: A register written in a cycle takes the written value even when an increment is due in that cycle. That register then passes no carry to the next register in that cycle.
- R11: `rd_data_o` shows the register that `rd_addr_i` selects, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase enable, TICK_DIV pulses per hundredth |
| wr_en_i | input | 1 | Whole-register write strobe |
| wr_addr_i | input | 3 | Register number to write |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Register number to read |
| rd_data_o | output | 8 | Read data |
| osc_off_o | output | 1 | Count-stop control bit |
| rst_ignore_o | output | 1 | Reset-ignore control bit |

## Verification
The range assertions on each counter fire only when the field already held a valid BCD value inside its range before the increment. A write may load anything, but no claim is made about what follows an increment of an out-of-range load. The bench loads a complete and valid calendar before every sweep vector, so each step starts from a legal state. The one test that writes all-ones, to expose the forced-zero bits, is followed by a full reload. Tick pulses are always one cycle wide. Writes coincide with ticks only in the tests aimed at the write-priority rule.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int REG_W    = 8;
   localparam int NUM_REGS = 8;
   localparam int ADDR_W   = $clog2(NUM_REGS);

   typedef enum logic [ADDR_W-1:0] {
      REG_CENTI = 3'd0,
      REG_SEC   = 3'd1,
      REG_MIN   = 3'd2,
      REG_HOUR  = 3'd3,
      REG_WDAY  = 3'd4,
      REG_DATE  = 3'd5,
      REG_MONTH = 3'd6,
      REG_YEAR  = 3'd7
   } reg_sel_e;

   // Counter-field storage masks (day field keeps only its count bits;
   // the control bits of that register live in the top).
   localparam logic [REG_W-1:0] FLD_MASK  [NUM_REGS] =
      '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h07, 8'h3F, 8'h1F, 8'hFF};
   // Last value before wrap (date entry is replaced by the month length).
   localparam logic [REG_W-1:0] FLD_CEIL  [NUM_REGS] =
      '{8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
   // Value after wrap.
   localparam logic [REG_W-1:0] FLD_FLOOR [NUM_REGS] =
      '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
   // Value after reset.
   localparam logic [REG_W-1:0] FLD_RST   [NUM_REGS] =
      '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

   // Add one to a two-digit BCD value.
   function automatic logic [REG_W-1:0] bcd_incr(input logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // Number of days (BCD) in a BCD month of a BCD two-digit year.
   function automatic logic [REG_W-1:0] month_days(input logic [4:0] mon,
                                                   input logic [REG_W-1:0] yr);
      logic [REG_W-1:0] ybin;
      logic             leap;
      logic [REG_W-1:0] d;
      ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
      leap = (ybin[1:0] == 2'b00);
      case (mon)
         5'h02:                      d = leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: d = 8'h30;
         default:                    d = 8'h31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rtc_tick_prescale.sv
module rtc_tick_prescale #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   input  logic clr_i,
   output logic step_o
);

   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("rtc_tick_prescale: TICK_DIV must be at least 1");
   end

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               phase_q <= '0;
      else if (clr_i)           phase_q <= '0;
      else if (tick_i && run_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
   end

   assign step_o = tick_i & run_i & (phase_q == LAST);

   if (TICK_DIV > 1) begin : g_gap_chk
      AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         step_o |=> !step_o); // R2
   end

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter logic [REG_W-1:0] MASK    = 8'hFF,
   parameter logic [REG_W-1:0] FLOOR   = 8'h00,
   parameter logic [REG_W-1:0] RST_VAL = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic [REG_W-1:0] ceil_i,
   output logic [REG_W-1:0] val_o,
   output logic             wrap_o
);

   if ((RST_VAL & ~MASK) != '0) begin : g_bad_rst
      $error("rtc_bcd_field: reset value outside storage mask");
   end
   if ((FLOOR & ~MASK) != '0) begin : g_bad_floor
      $error("rtc_bcd_field: wrap value outside storage mask");
   end

   logic [REG_W-1:0] val_q;
   logic             at_top;

   assign at_top = (val_q >= ceil_i);
   assign wrap_o = inc_i & ~wr_i & at_top;

   always_ff @(posedge clk) begin
      if (!rst_n)     val_q <= RST_VAL;
      else if (wr_i)  val_q <= wr_data_i & MASK;
      else if (inc_i) val_q <= at_top ? FLOOR : (bcd_incr(val_q) & MASK);
   end

   assign val_o = val_q;

   AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (val_q == ($past(wr_data_i) & MASK))); // R10

   AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && val_q >= FLOOR && val_q <= ceil_i && val_q[3:0] <= 4'd9)
      |=> (val_q[3:0] <= 4'd9 && val_q >= FLOOR && val_q <= $past(ceil_i))); // R1

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
   import rtc_cal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] val_o,
   output logic             wrap_o
);

   localparam logic [REG_W-1:0] HR_MASK = 8'hBF;

   logic [REG_W-1:0] val_q;
   logic [REG_W-1:0] nxt;
   logic             roll;

   logic       mode12;
   logic       pm;
   logic [4:0] h12;
   logic [5:0] h24;

   assign mode12 = val_q[7];
   assign pm     = val_q[5];
   assign h12    = val_q[4:0];
   assign h24    = val_q[5:0];

   always_comb begin
      nxt  = val_q;
      roll = 1'b0;
      if (mode12) begin
         if (h12 == 5'h11) begin
            nxt  = {1'b1, 1'b0, ~pm, 5'h12};
            roll = pm;
         end else if (h12 >= 5'h12) begin
            nxt = {1'b1, 1'b0, pm, 5'h01};
         end else if (h12[3:0] >= 4'd9) begin
            nxt = {1'b1, 1'b0, pm, 1'b1, 4'h0};
         end else begin
            nxt = {1'b1, 1'b0, pm, h12[4], h12[3:0] + 4'd1};
         end
      end else begin
         if (h24 >= 6'h23) begin
            nxt  = 8'h00;
            roll = 1'b1;
         end else if (h24[3:0] >= 4'd9) begin
            nxt = {2'b00, h24[5:4] + 2'd1, 4'h0};
         end else begin
            nxt = {2'b00, h24[5:4], h24[3:0] + 4'd1};
         end
      end
   end

   assign wrap_o = inc_i & ~wr_i & roll;

   always_ff @(posedge clk) begin
      if (!rst_n)     val_q <= '0;
      else if (wr_i)  val_q <= wr_data_i & HR_MASK;
      else if (inc_i) val_q <= nxt;
   end

   assign val_o = val_q;

   AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && val_q[7] && val_q[4:0] >= 5'h01 && val_q[4:0] <= 5'h12
       && val_q[3:0] <= 4'd9)
      |=> (val_q[7] && val_q[4:0] >= 5'h01 && val_q[4:0] <= 5'h12)); // R4

   AST_PM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && val_q[7] && val_q[4:0] != 5'h11)
      |=> (val_q[5] == $past(val_q[5]))); // R4

   AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_i && !val_q[7] && val_q[5:0] <= 6'h23 && val_q[3:0] <= 4'd9)
      |=> (!val_q[7] && val_q[5:0] <= 6'h23 && val_q[3:0] <= 4'd9)); // R3

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int TICK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o,
   output logic              osc_off_o,
   output logic              rst_ignore_o
);

   if (NUM_REGS != 8 || REG_W != 8) begin : g_bad_map
      $error("rtc_calendar_core: register map must be eight bytes");
   end

   logic [REG_W-1:0]    fld [NUM_REGS];
   logic [NUM_REGS-1:0] wr_sel;
   logic [NUM_REGS-1:0] wrap;
   logic [NUM_REGS-1:0] inc;
   logic                osc_off_q;
   logic                rst_ign_q;
   logic                step;

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         wr_sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
      end
   end

   rtc_tick_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .run_i  (~osc_off_q),
      .clr_i  (wr_sel[REG_CENTI]),
      .step_o (step)
   );

   // Carry chain: day of week and date both follow the hour wrap.
   always_comb begin
      inc            = '0;
      inc[REG_CENTI] = step;
      inc[REG_SEC]   = wrap[REG_CENTI];
      inc[REG_MIN]   = wrap[REG_SEC];
      inc[REG_HOUR]  = wrap[REG_MIN];
      inc[REG_WDAY]  = wrap[REG_HOUR];
      inc[REG_DATE]  = wrap[REG_HOUR];
      inc[REG_MONTH] = wrap[REG_DATE];
      inc[REG_YEAR]  = wrap[REG_MONTH];
   end

   logic unused_wraps;
   assign unused_wraps = wrap[REG_WDAY] ^ wrap[REG_YEAR];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_fld
      if (g == int'(REG_HOUR)) begin : g_hour
         rtc_hour_field u_hour (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[g]),
            .wr_i      (wr_sel[g]),
            .wr_data_i (wr_data_i),
            .val_o     (fld[g]),
            .wrap_o    (wrap[g])
         );
      end else begin : g_bcd
         logic [REG_W-1:0] ceil_l;
         if (g == int'(REG_DATE)) begin : g_dyn
            assign ceil_l = month_days(fld[REG_MONTH][4:0], fld[REG_YEAR]);
         end else begin : g_fix
            assign ceil_l = FLD_CEIL[g];
         end
         rtc_bcd_field #(
            .MASK    (FLD_MASK[g]),
            .FLOOR   (FLD_FLOOR[g]),
            .RST_VAL (FLD_RST[g])
         ) u_fld (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[g]),
            .wr_i      (wr_sel[g]),
            .wr_data_i (wr_data_i),
            .ceil_i    (ceil_l),
            .val_o     (fld[g]),
            .wrap_o    (wrap[g])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         osc_off_q <= 1'b1;
         rst_ign_q <= 1'b1;
      end else if (wr_sel[REG_WDAY]) begin
         osc_off_q <= wr_data_i[5];
         rst_ign_q <= wr_data_i[4];
      end
   end

   always_comb begin
      if (rd_addr_i == REG_WDAY)
         rd_data_o = {2'b00, osc_off_q, rst_ign_q, 1'b0, fld[REG_WDAY][2:0]};
      else
         rd_data_o = fld[rd_addr_i];
   end

   assign osc_off_o    = osc_off_q;
   assign rst_ignore_o = rst_ign_q;

   AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_off_q && !wr_en_i) |=> $stable(fld[REG_CENTI])); // R7

   AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[REG_WDAY] && !wr_sel[REG_WDAY] && fld[REG_WDAY] >= 8'h01 && fld[REG_WDAY] <= 8'h07)
      |=> (fld[REG_WDAY] >= 8'h01 && fld[REG_WDAY] <= 8'h07)); // R5

endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;

   localparam int DIV      = 3;
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       osc_off;
   logic       rst_ign;

   int nvec  = 0;
   int nfail = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   rtc_calendar_core #(.TICK_DIV(DIV)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .rd_addr_i    (rd_addr),
      .rd_data_o    (rd_data),
      .osc_off_o    (osc_off),
      .rst_ignore_o (rst_ign)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         nfail = nfail + 1;
         $display("FAIL watchdog (all requirements): actual cycles=%0d expected below %0d",
                  cyc, WD_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   function automatic logic [7:0] bcd(input int n);
      return 8'(((n / 10) * 16) + (n % 10));
   endfunction

   function automatic int dim(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int n);
      repeat (n) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   // Tick pulse with a register write in the same cycle.
   task automatic pulse_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      nvec = nvec + 1;
      if (rd_data !== exp) begin
         nfail = nfail + 1;
         $display("FAIL %s reg%0d actual=%h expected=%h", req, a, rd_data, exp);
      end
   endtask

   task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
      nvec = nvec + 1;
      if (act !== exp) begin
         nfail = nfail + 1;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Full reload; hundredths last so the prescaler phase starts at zero.
   task automatic set_all(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                          input logic [7:0] hs, input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
      wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dw);
      wr(3'd3, h);  wr(3'd2, mi); wr(3'd1, s);  wr(3'd0, hs);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset contents and control bits
      chk("R8", 3'd0, 8'h00); chk("R8", 3'd1, 8'h00); chk("R8", 3'd2, 8'h00);
      chk("R8", 3'd3, 8'h00); chk("R8", 3'd4, 8'h31); chk("R8", 3'd5, 8'h01);
      chk("R8", 3'd6, 8'h01); chk("R8", 3'd7, 8'h00);
      chk_bit("R8", "osc_off_o", osc_off, 1'b1);
      chk_bit("R8", "rst_ignore_o", rst_ign, 1'b1);
      // R7: stopped after reset, ticks do nothing
      pulse(2 * DIV);
      chk("R7", 3'd0, 8'h00);

      // R9 and R11: forced-zero bits, read back through the read port
      for (int i = 1; i <= 6; i++) wr(3'(i), 8'hFF);
      chk("R9", 3'd1, 8'h7F); chk("R9", 3'd2, 8'h7F); chk("R9", 3'd3, 8'hBF);
      chk("R9", 3'd4, 8'h37); chk("R9", 3'd5, 8'h3F); chk("R9", 3'd6, 8'h1F);
      wr(3'd0, 8'h5A); wr(3'd7, 8'hA5);
      chk("R11", 3'd0, 8'h5A); chk("R11", 3'd7, 8'hA5);

      // R7: control bits
      set_all(8'h10, 8'h20, 8'h30, 8'h10, 8'h21, 8'h05, 8'h03, 8'h20);
      chk_bit("R7", "osc_off_o", osc_off, 1'b1);
      chk_bit("R7", "rst_ignore_o", rst_ign, 1'b0);
      pulse(2 * DIV);
      chk("R7", 3'd0, 8'h10);
      wr(3'd4, 8'h11);
      chk_bit("R7", "osc_off_o", osc_off, 1'b0);
      chk_bit("R7", "rst_ignore_o", rst_ign, 1'b1);
      chk("R7", 3'd4, 8'h11);
      pulse(DIV);
      chk("R7", 3'd0, 8'h11);

      // R2: prescale ratio and phase restart on hundredths write
      set_all(8'h01, 8'h00, 8'h00, 8'h40, 8'h01, 8'h01, 8'h01, 8'h01);
      pulse(DIV - 1);
      chk("R2", 3'd0, 8'h40);
      pulse(1);
      chk("R2", 3'd0, 8'h41);
      pulse(DIV - 1);
      wr(3'd0, 8'h50);
      pulse(DIV - 1);
      chk("R2", 3'd0, 8'h50);
      pulse(1);
      chk("R2", 3'd0, 8'h51);

      // R10: write wins over a due increment
      set_all(8'h01, 8'h00, 8'h10, 8'h99, 8'h01, 8'h01, 8'h01, 8'h01);
      pulse(DIV - 1);
      pulse_wr(3'd0, 8'h42);
      chk("R10", 3'd0, 8'h42);
      chk("R10", 3'd1, 8'h10);
      set_all(8'h01, 8'h00, 8'h10, 8'h99, 8'h01, 8'h01, 8'h01, 8'h01);
      pulse(DIV - 1);
      pulse_wr(3'd1, 8'h30);
      chk("R10", 3'd0, 8'h00);
      chk("R10", 3'd1, 8'h30);
      chk("R10", 3'd2, 8'h00);

      // R1: hundredths run through a full second
      set_all(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01);
      for (int i = 1; i <= 100; i++) begin
         pulse(DIV);
         chk("R1", 3'd0, bcd(i % 100));
      end
      chk("R1", 3'd1, 8'h01);

      // R1: seconds sweep
      for (int s = 0; s < 60; s++) begin
         set_all(8'h00, 8'h00, bcd(s), 8'h99, 8'h01, 8'h01, 8'h01, 8'h01);
         pulse(DIV);
         chk("R1", 3'd1, bcd((s + 1) % 60));
         chk("R1", 3'd2, (s == 59) ? 8'h01 : 8'h00);
      end

      // R1: minutes sweep
      for (int m = 0; m < 60; m++) begin
         set_all(8'h00, bcd(m), 8'h59, 8'h99, 8'h01, 8'h01, 8'h01, 8'h01);
         pulse(DIV);
         chk("R1", 3'd2, bcd((m + 1) % 60));
         chk("R1", 3'd3, (m == 59) ? 8'h01 : 8'h00);
      end

      // R3: 24-hour sweep
      for (int h = 0; h < 24; h++) begin
         set_all(bcd(h), 8'h59, 8'h59, 8'h99, 8'h02, 8'h15, 8'h06, 8'h10);
         pulse(DIV);
         chk("R3", 3'd3, bcd((h + 1) % 24));
         chk("R3", 3'd5, (h == 23) ? 8'h16 : 8'h15);
      end

      // R4: 12-hour sweep, both halves of the day
      for (int p = 0; p < 2; p++) begin
         for (int h = 1; h <= 12; h++) begin
            int nh;
            int np;
            logic carry;
            nh = (h == 12) ? 1 : h + 1;
            np = (h == 11) ? 1 - p : p;
            carry = (h == 11) && (p == 1);
            set_all(8'h80 | 8'(p << 5) | bcd(h), 8'h59, 8'h59, 8'h99,
                    8'h03, 8'h15, 8'h06, 8'h10);
            pulse(DIV);
            chk("R4", 3'd3, 8'h80 | 8'(np << 5) | bcd(nh));
            chk("R4", 3'd5, carry ? 8'h16 : 8'h15);
            chk("R4", 3'd4, carry ? 8'h04 : 8'h03);
         end
      end

      // R5: day of week sweep
      for (int d = 1; d <= 7; d++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'(d), 8'h10, 8'h06, 8'h10);
         pulse(DIV);
         chk("R5", 3'd4, 8'((d % 7) + 1));
         chk("R5", 3'd5, 8'h11);
      end

      // R6: last day of each month in a non-leap year
      for (int m = 1; m <= 12; m++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, bcd(dim(m, 1)), bcd(m), 8'h01);
         pulse(DIV);
         chk("R6", 3'd5, 8'h01);
         chk("R6", 3'd6, bcd((m % 12) + 1));
         chk("R6", 3'd7, (m == 12) ? 8'h02 : 8'h01);
      end

      // R6: day before the last stays in the month
      set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h29, 8'h04, 8'h01);
      pulse(DIV);
      chk("R6", 3'd5, 8'h30);
      chk("R6", 3'd6, 8'h04);

      // R6: February 28 across every year value
      for (int y = 0; y < 100; y++) begin
         set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, bcd(y));
         pulse(DIV);
         chk("R6", 3'd5, (y % 4 == 0) ? 8'h29 : 8'h01);
         chk("R6", 3'd6, (y % 4 == 0) ? 8'h02 : 8'h03);
      end

      // R6: February 29 in a leap year, and year 99 wrap
      set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h29, 8'h02, 8'h04);
      pulse(DIV);
      chk("R6", 3'd5, 8'h01);
      chk("R6", 3'd6, 8'h03);
      set_all(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h31, 8'h12, 8'h99);
      pulse(DIV);
      chk("R6", 3'd7, 8'h00);
      chk("R6", 3'd6, 8'h01);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule